// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a link to a 16-bit-word serial EEPROM that uses chip select, serial clock, data in and data out. A client hands it one request at a time (read a word, write a word, allow programming, forbid programming), together with an address and write data. The block builds the serial frame, generates the serial clock from the system clock through a programmable divider, shifts the frame out, and for reads collects the returned word. It raises a one-cycle completion pulse when the device is deselected again.

A write ends with its own handshake. Chip select drops right after the last data bit. It stays low for the minimum deselect time and then rises again. The controller then watches data out until the device reports ready, and it gives up after a programmable number of clocks with a timeout flag. The device starts up with programming forbidden. The controller therefore keeps a shadow of that state, and it sends the allow-programming frame by itself ahead of any write that would otherwise be rejected.

Top module: `sereep_host`

## Requirements
- R1: Each frame begins with a 1 start bit, then a two-bit opcode, then ADDR_W address bits, most significant bit first. A read uses opcode 10. The controller lets one clock of data out pass unused (the dummy bit), then shifts in 16 data bits, most significant first, and presents them on rdData with the completion pulse. A write uses opcode 01 and is followed by 16 data bits, most significant first.
- R2: Enable-programming (reqCmd 2) is sent as opcode 00 with the two top address bits 11. Disable-programming (reqCmd 3) is sent as opcode 00 with the two top address bits 00. All lower address bits are sent as 0 in both cases. Read is reqCmd 0 and write is reqCmd 1.
- R3: Serial data out of the controller changes only while the serial clock is low. The serial clock stays high for exactly HALF_DIV system clocks in each bit, and it is never high while chip select is low.
- R4: Between any two chip-select high periods, chip select stays low for at least CS_LOW_CYC system clocks.
- R5: After the last write data bit, chip select falls before any further serial clock rising edge. After the gap it rises again and stays high until data out reads 1.
- R6: If data out stays 0 for POLL_MAX clocks of polling, the controller ends the request and raises timedOut together with the completion pulse. A request that completes normally reports timedOut low.
- R7: Programming counts as forbidden after reset and after a disable request. A write issued in that state is sent after one automatically inserted enable frame. A write issued while programming is allowed gets no extra frame.
- R8: reqReady is high only while idle. A reqValid given while reqReady is low has no effect. Each accepted request produces exactly one single-cycle done pulse, issued while reqReady is high.
- R9: During and right after reset, chip select and the serial clock are low, reqReady is high, and done and timedOut are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken only while reqReady is high |
| reqCmd | input | 2 | 0 read, 1 write, 2 enable programming, 3 disable programming |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Word to write |
| reqReady | output | 1 | Idle, can accept a request |
| rdData | output | DATA_W | Word returned by the last read |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | Last write ended without a ready indication |
| csOut | output | 1 | Chip select to the device, active high |
| skOut | output | 1 | Serial clock to the device |
| diOut | output | 1 | Serial data to the device |
| doIn | input | 1 | Serial data from the device, also busy (0) / ready (1) |

## Verification
A behavioural device model decodes every frame, holds a word array and a programming-allowed flag, and drives busy and then ready after writes for a randomly chosen number of clocks. Directed sequences cover these cases: the first write after reset, a second write, a write after a disable request, an explicit enable, and a read while programming is forbidden. These separate the automatic enable insertion from ordinary framing. A device that never turns ready exercises the timeout path, and the next normal write shows the flag clearing. A request strobed mid-operation shows that it is ignored. A random mix of reads and writes at random addresses, with random data and busy times, checks that data, address and bit order come back intact. The model also counts clock-phase, deselect-gap and extra-clock violations.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_WREN  = 2'd2,
    CMD_WRDIS = 2'd3
  } cmd_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_MISC  = 2'b00;
  localparam logic [1:0] SUB_WREN  = 2'b11;
  localparam logic [1:0] SUB_WRDIS = 2'b00;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;  // capture request fields
    logic loadEn;    // load an enable-programming frame
    logic loadCmd;   // load the frame of the latched request
    logic timerClr;  // restart the wait timer
  } dpCtl_t;

endpackage

// File: rtl/sereep_dp.sv
module sereep_dp
  import sereep_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int HALF_DIV = 4,
  parameter int TMR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [1:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              doIn,
  output logic              skOut,
  output logic              diOut,
  output logic [DATA_W-1:0] rdData,
  output logic              frameEnd,
  output logic [TMR_W-1:0]  timer
);

  localparam int HDR_W   = 3 + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int RD_BITS = HDR_W + 1 + DATA_W;
  localparam int CNT_W   = $clog2(RD_BITS + 1);
  localparam int DIV_W   = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] CAP_FIRST = CNT_W'(HDR_W + 1);

  logic [1:0]         cmdQ;
  logic [ADDR_W-1:0]  addrQ;
  logic [DATA_W-1:0]  wdataQ;
  logic [FRAME_W-1:0] frameSh;
  logic [CNT_W-1:0]   bitCnt;
  logic [CNT_W-1:0]   bitTotal;
  logic [DIV_W-1:0]   divCnt;
  logic               active;
  logic               capEn;
  logic               skQ;
  logic [DATA_W-1:0]  rdSh;

  function automatic logic [FRAME_W-1:0] buildFrame(
    input logic [1:0]        cmd,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data
  );
    logic [FRAME_W-1:0] f;
    case (cmd_e'(cmd))
      CMD_READ:  f = {1'b1, OP_READ, addr, {DATA_W{1'b0}}};
      CMD_WRITE: f = {1'b1, OP_WRITE, addr, data};
      CMD_WREN:  f = {1'b1, OP_MISC, SUB_WREN, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
      default:   f = {1'b1, OP_MISC, SUB_WRDIS, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
    endcase
    return f;
  endfunction

  function automatic logic [CNT_W-1:0] frameLen(input logic [1:0] cmd);
    case (cmd_e'(cmd))
      CMD_READ:  return CNT_W'(RD_BITS);
      CMD_WRITE: return CNT_W'(FRAME_W);
      default:   return CNT_W'(HDR_W);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ     <= '0;
      addrQ    <= '0;
      wdataQ   <= '0;
      frameSh  <= '0;
      bitCnt   <= '0;
      bitTotal <= '0;
      divCnt   <= '0;
      active   <= 1'b0;
      capEn    <= 1'b0;
      skQ      <= 1'b0;
      rdSh     <= '0;
      frameEnd <= 1'b0;
    end else begin
      frameEnd <= 1'b0;
      if (ctl.latchReq) begin
        cmdQ   <= reqCmd;
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.loadEn || ctl.loadCmd) begin
        frameSh  <= ctl.loadEn ? buildFrame(CMD_WREN, addrQ, wdataQ)
                               : buildFrame(cmdQ, addrQ, wdataQ);
        bitTotal <= ctl.loadEn ? frameLen(CMD_WREN) : frameLen(cmdQ);
        capEn    <= ctl.loadCmd && (cmdQ == CMD_READ);
        bitCnt   <= '0;
        divCnt   <= '0;
        skQ      <= 1'b0;
        active   <= 1'b1;
      end else if (active) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          skQ    <= ~skQ;
          if (skQ) begin
            // end of the high phase: bit complete, next bit set up while low
            frameSh <= frameSh << 1;
            if (capEn && bitCnt >= CAP_FIRST) rdSh <= {rdSh[DATA_W-2:0], doIn};
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == bitTotal - 1'b1) begin
              active   <= 1'b0;
              frameEnd <= 1'b1;
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             timer <= '0;
    else if (ctl.timerClr) timer <= '0;
    else if (timer != '1)  timer <= timer + 1'b1;
  end

  assign skOut  = skQ;
  assign diOut  = frameSh[FRAME_W-1];
  assign rdData = rdSh;

endmodule

// File: rtl/sereep_ctrl.sv
module sereep_ctrl
  import sereep_pkg::*;
#(
  parameter int CS_LOW_CYC = 5,
  parameter int POLL_MAX   = 1000,
  parameter int TMR_W      = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqCmd,
  input  logic             frameEnd,
  input  logic [TMR_W-1:0] timer,
  input  logic             doIn,
  output dpCtl_t           ctl,
  output logic             csOut,
  output logic             reqReady,
  output logic             done,
  output logic             timedOut
);

  localparam logic [TMR_W-1:0] GAP_LAST  = TMR_W'(CS_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] POLL_LAST = TMR_W'(POLL_MAX - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_SHIFT, ST_GAP, ST_POLL, ST_DESEL
  } state_e;

  state_e     state, nxt;
  logic [1:0] cmdQ;
  logic       wrEn;    // shadow of the device programming-allowed state
  logic       pendWr;  // enable frame in flight ahead of a write
  logic       toFlag;

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        ctl.latchReq = 1'b1;
        nxt = ST_START;
      end
      ST_START: begin
        if (cmdQ == CMD_WRITE && !wrEn) ctl.loadEn = 1'b1;
        else                            ctl.loadCmd = 1'b1;
        nxt = ST_SHIFT;
      end
      ST_SHIFT: if (frameEnd) begin
        ctl.timerClr = 1'b1;
        nxt = (cmdQ == CMD_WRITE && !pendWr) ? ST_GAP : ST_DESEL;
      end
      ST_GAP: if (timer == GAP_LAST) begin
        ctl.timerClr = 1'b1;
        nxt = ST_POLL;
      end
      ST_POLL: if (doIn || timer == POLL_LAST) begin
        ctl.timerClr = 1'b1;
        nxt = ST_DESEL;
      end
      ST_DESEL: if (timer == GAP_LAST) nxt = pendWr ? ST_START : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cmdQ     <= '0;
      wrEn     <= 1'b0;
      pendWr   <= 1'b0;
      toFlag   <= 1'b0;
      done     <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      state <= nxt;
      done  <= 1'b0;
      if (ctl.latchReq) begin
        cmdQ     <= reqCmd;
        toFlag   <= 1'b0;
        timedOut <= 1'b0;
      end
      if (ctl.loadEn) begin
        wrEn   <= 1'b1;
        pendWr <= 1'b1;
      end
      if (ctl.loadCmd) begin
        if (cmdQ == CMD_WREN)       wrEn <= 1'b1;
        else if (cmdQ == CMD_WRDIS) wrEn <= 1'b0;
      end
      if (state == ST_POLL && !doIn && timer == POLL_LAST) toFlag <= 1'b1;
      if (state == ST_DESEL && timer == GAP_LAST) begin
        if (pendWr) pendWr <= 1'b0;
        else begin
          done     <= 1'b1;
          timedOut <= toFlag;
        end
      end
    end
  end

  assign csOut    = (state == ST_SHIFT) || (state == ST_POLL);
  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sereep_host.sv
module sereep_host
  import sereep_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int HALF_DIV   = 4,
  parameter int CS_LOW_CYC = 5,
  parameter int POLL_MAX   = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              timedOut,
  output logic              csOut,
  output logic              skOut,
  output logic              diOut,
  input  logic              doIn
);

  localparam int WAIT_MAX = (CS_LOW_CYC > POLL_MAX) ? CS_LOW_CYC : POLL_MAX;
  localparam int TMR_W    = $clog2(WAIT_MAX + 1);

  dpCtl_t           ctl;
  logic             frameEnd;
  logic [TMR_W-1:0] timer;

  sereep_ctrl #(
    .CS_LOW_CYC(CS_LOW_CYC), .POLL_MAX(POLL_MAX), .TMR_W(TMR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .frameEnd(frameEnd), .timer(timer), .doIn(doIn), .ctl(ctl),
    .csOut(csOut), .reqReady(reqReady), .done(done), .timedOut(timedOut)
  );

  sereep_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .TMR_W(TMR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqCmd(reqCmd), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .doIn(doIn), .skOut(skOut), .diOut(diOut),
    .rdData(rdData), .frameEnd(frameEnd), .timer(timer)
  );

endmodule

// File: rtl/sereep_chk.sv
module sereep_chk #(
  parameter int HALF_DIV   = 4,
  parameter int CS_LOW_CYC = 5
) (
  input logic clk,
  input logic rstN,
  input logic csOut,
  input logic skOut,
  input logic diOut,
  input logic done,
  input logic reqReady,
  input logic timedOut
);

  localparam int LW = $clog2(CS_LOW_CYC + 2);
  localparam int HW = $clog2(HALF_DIV + 2);
  localparam logic [LW-1:0] LOW_SAT = LW'(CS_LOW_CYC);
  localparam logic [HW-1:0] HI_SAT  = HW'(HALF_DIV + 1);

  logic [LW-1:0] lowCnt;
  logic [HW-1:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= LOW_SAT;
      hiCnt  <= '0;
    end else begin
      if (csOut)                 lowCnt <= '0;
      else if (lowCnt < LOW_SAT) lowCnt <= lowCnt + 1'b1;
      if (!skOut)                hiCnt <= '0;
      else if (hiCnt < HI_SAT)   hiCnt <= hiCnt + 1'b1;
    end
  end

  a_r3_sk_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    !csOut |-> !skOut);
  a_r3_di_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    (skOut && $past(skOut)) |-> $stable(diOut));
  a_r3_sk_high_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(skOut) |-> (hiCnt == HW'(HALF_DIV)));
  a_r4_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csOut) |-> (lowCnt >= LOW_SAT));
  a_r6_timeout_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> done);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);
  a_r8_idle_deselected: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !csOut);

endmodule

bind sereep_host sereep_chk #(
  .HALF_DIV(HALF_DIV), .CS_LOW_CYC(CS_LOW_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .csOut(csOut), .skOut(skOut), .diOut(diOut),
  .done(done), .reqReady(reqReady), .timedOut(timedOut)
);

// File: tb/sim_sereep_host.sv
module sim_sereep_host;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int HALF = 2;
  localparam int GAP  = 5;
  localparam int PMAX = 100;
  localparam int HDR  = AW + 2;
  localparam int NW   = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqCmd = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, done, timedOut, csOut, skOut, diOut;
  logic [DW-1:0] rdData;
  logic doReg = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sereep_host #(.ADDR_W(AW), .DATA_W(DW), .HALF_DIV(HALF),
                .CS_LOW_CYC(GAP), .POLL_MAX(PMAX)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rdData(rdData), .done(done), .timedOut(timedOut), .csOut(csOut),
    .skOut(skOut), .diOut(diOut), .doIn(doReg)
  );

  int nChk = 0, nErr = 0, cyc = 0, doneSeen = 0;

  // ---------------- device model ----------------
  localparam int M_HUNT = 0, M_HDR = 1, M_RD = 2, M_WR = 3, M_WRFULL = 4, M_END = 5;
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] expMem [NW];
  int mState = M_HUNT, hdrCnt = 0, datCnt = 0, rdCnt = 0, busyCnt = 0, busyLen = 20;
  int csLowRun = 0, skHiRun = 0;
  logic [HDR-1:0] hdrSh = '0;
  logic [DW-1:0] datSh = '0;
  logic [AW-1:0] mAddr = '0;
  logic en = 1'b0, pollMode = 1'b0, stuck = 1'b0, sawCs = 1'b0;
  logic skPrev = 1'b0, csPrev = 1'b0, diPrev = 1'b0;
  int violDi = 0, violGap = 0, violExtra = 0, violSk = 0, badFrame = 0;
  int ewenSeen = 0, ewdsSeen = 0, rdFrames = 0, wrFrames = 0, rejWr = 0;

  function automatic logic [DW-1:0] initWord(input int i);
    return DW'(i * 16'h0101) ^ 16'hA5C3;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      en = 1'b0; mState = M_HUNT; pollMode = 1'b0; busyCnt = 0; doReg = 1'b0;
      skPrev = 1'b0; csPrev = 1'b0; diPrev = 1'b0; csLowRun = 0; skHiRun = 0;
    end else begin
      if (skOut && skPrev && diOut != diPrev) violDi++;
      if (skOut && !csOut) violSk++;
      if (skOut) skHiRun++;
      else begin
        if (skPrev && skHiRun != HALF) violSk++;
        skHiRun = 0;
      end
      if (!csOut) csLowRun++;
      else begin
        if (!csPrev && sawCs && csLowRun < GAP) violGap++;
        if (!csPrev) sawCs = 1'b1;
        csLowRun = 0;
      end
      if (busyCnt > 0) busyCnt--;
      if (!csOut && csPrev) begin
        if (mState == M_WRFULL) begin
          if (en) begin mem[mAddr] = datSh; busyCnt = busyLen; end
          else rejWr++;
          pollMode = 1'b1;
        end
        mState = M_HUNT;
      end
      if (csOut && skOut && !skPrev) begin
        case (mState)
          M_HUNT: if (diOut) begin mState = M_HDR; hdrCnt = 0; pollMode = 1'b0; end
          M_HDR: begin
            hdrSh = {hdrSh[HDR-2:0], diOut};
            hdrCnt++;
            if (hdrCnt == HDR) begin
              mAddr = hdrSh[AW-1:0];
              case (hdrSh[HDR-1:AW])
                2'b10: begin mState = M_RD; rdCnt = 0; rdFrames++; end
                2'b01: begin mState = M_WR; datCnt = 0; wrFrames++; end
                2'b00: begin
                  if (hdrSh[AW-3:0] != '0) badFrame++;
                  if (hdrSh[AW-1:AW-2] == 2'b11) begin en = 1'b1; ewenSeen++; end
                  else if (hdrSh[AW-1:AW-2] == 2'b00) begin en = 1'b0; ewdsSeen++; end
                  else badFrame++;
                  mState = M_END;
                end
                default: begin badFrame++; mState = M_END; end
              endcase
            end
          end
          M_RD: begin
            if (rdCnt > DW) violExtra++;
            else doReg = (rdCnt == 0) ? 1'b0 : mem[mAddr][DW - rdCnt];
            rdCnt++;
          end
          M_WR: begin
            datSh = {datSh[DW-2:0], diOut};
            datCnt++;
            if (datCnt == DW) mState = M_WRFULL;
          end
          default: violExtra++;
        endcase
      end
      if (!csOut) doReg = 1'b0;
      else if (pollMode) doReg = (busyCnt == 0) && !stuck;
      else if (mState != M_RD) doReg = 1'b0;
      skPrev = skOut; csPrev = csOut; diPrev = diOut;
    end
  end

  always @(negedge clk) if (rstN && done) doneSeen++;

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [DW-1:0] lastRd;
  logic lastTo;

  task automatic runReq(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int g = 0;
    while (!reqReady) @(negedge clk);
    reqCmd = c; reqAddr = a; reqWdata = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && g < 20000) begin @(negedge clk); g++; end
    if (!done) chk(1'b0, "R8", "done never seen", 0, 1);
    lastRd = rdData; lastTo = timedOut;
    if (c == 2'd1) expMem[a] = d;
    @(negedge clk);
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input string req);
    runReq(2'd0, a, '0);
    chk(lastRd == expMem[a], req, "read word", 32'(lastRd), 32'(expMem[a]));
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nErr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    int e0, d0, r0, w0;
    void'($urandom(32'd7321));
    for (int i = 0; i < NW; i++) begin mem[i] = initWord(i); expMem[i] = initWord(i); end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!csOut && !skOut, "R9", "cs/sk in reset", {csOut, skOut}, 0);
    chk(reqReady && !done && !timedOut, "R9", "ready/done/to in reset",
        {reqReady, done, timedOut}, 3'b100);
    rstN = 1'b1;
    @(negedge clk);
    chk(!csOut && !skOut && reqReady && !done && !timedOut, "R9", "after release",
        {csOut, skOut, reqReady, done, timedOut}, 5'b00100);

    // R7: first write after reset gets an inserted enable
    e0 = ewenSeen; d0 = doneSeen;
    runReq(2'd1, 6'd5, 16'h1234);
    chk(ewenSeen == e0 + 1, "R7", "enable inserted after reset", ewenSeen - e0, 1);
    chk(doneSeen == d0 + 1, "R8", "one done per request", doneSeen - d0, 1);
    chk(!lastTo, "R6", "normal write timedOut", lastTo, 0);
    readCheck(6'd5, "R1");
    readCheck(6'd63, "R1");
    e0 = ewenSeen;
    runReq(2'd1, 6'd63, 16'h8001);
    chk(ewenSeen == e0, "R7", "no enable when allowed", ewenSeen - e0, 0);
    readCheck(6'd63, "R5");

    // R2: disable then read still works, then write re-enables
    d0 = ewdsSeen;
    runReq(2'd3, 6'd0, '0);
    chk(ewdsSeen == d0 + 1 && !en, "R2", "disable frame decoded", {en, 8'(ewdsSeen - d0)}, 1);
    readCheck(6'd5, "R1");
    e0 = ewenSeen;
    runReq(2'd1, 6'd0, 16'hFFFF);
    chk(ewenSeen == e0 + 1, "R7", "enable inserted after disable", ewenSeen - e0, 1);
    readCheck(6'd0, "R1");
    e0 = ewenSeen;
    runReq(2'd3, 6'd0, '0);
    runReq(2'd2, 6'h3F, '0);
    chk(ewenSeen == e0 + 1 && en, "R2", "enable frame decoded", {en, 8'(ewenSeen - e0)}, 9'h101);
    e0 = ewenSeen;
    runReq(2'd1, 6'd21, 16'h0F0F);
    chk(ewenSeen == e0, "R7", "explicit enable honoured", ewenSeen - e0, 0);

    // R6: device never reports ready
    stuck = 1'b1;
    runReq(2'd1, 6'd9, 16'hBEEF);
    chk(lastTo, "R6", "timeout flagged", lastTo, 1);
    stuck = 1'b0;
    runReq(2'd1, 6'd10, 16'h00AA);
    chk(!lastTo, "R6", "timeout cleared", lastTo, 0);
    readCheck(6'd9, "R5");

    // R8: a strobe while busy is ignored
    while (!reqReady) @(negedge clk);
    r0 = rdFrames; w0 = wrFrames; d0 = doneSeen;
    reqCmd = 2'd1; reqAddr = 6'd33; reqWdata = 16'h5A5A; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (6) @(negedge clk);
    chk(!reqReady, "R8", "not ready while busy", reqReady, 0);
    reqCmd = 2'd0; reqAddr = 6'd1; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    expMem[33] = 16'h5A5A;
    repeat (400) @(negedge clk);
    chk(rdFrames == r0 && wrFrames == w0 + 1, "R8", "ignored request frames",
        rdFrames - r0, 0);
    chk(doneSeen == d0 + 1 && reqReady, "R8", "single done", doneSeen - d0, 1);
    readCheck(6'd33, "R1");

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom_range(0, NW - 1));
      busyLen = $urandom_range(3, 80);
      if ($urandom_range(0, 2) == 0) runReq(2'd1, a, DW'($urandom));
      else readCheck(a, "R1");
    end

    // protocol monitors
    chk(violDi == 0 && violSk == 0, "R3", "clock phase violations", violDi + violSk, 0);
    chk(violGap == 0, "R4", "short deselect gaps", violGap, 0);
    chk(violExtra == 0, "R5", "extra clocks after frame", violExtra, 0);
    chk(badFrame == 0, "R2", "malformed frames", badFrame, 0);
    chk(rejWr == 0, "R7", "writes rejected by device", rejWr, 0);

    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

endmodule